// File: doc/BRIEF.md
# Ethernet Receive Elastic Buffer

This block sits between a receive byte stream clocked by a recovered clock and a local system clock, where the two clocks come from independent oscillators. Every write-clock cycle with the write enable high offers one symbol: a data byte plus a flag that marks it as an idle (gap) symbol. Every read-clock cycle, once the buffer has been primed, one symbol leaves on the read side. Read and write positions cross between the clock domains as gray code through two-flop synchronizers.

The clocks differ slightly in frequency, so the fill level drifts during a frame. The buffer corrects the drift only inside the interframe gap. When the level is too high, the write side discards an idle that follows another idle. When the level is too low, the read side repeats an idle instead of taking the next entry. Frame bytes are never dropped or duplicated by this correction. The default depth of 64 with a midpoint of 32 leaves 31 entries of margin on each side of the midpoint. That margin covers a full 1522-byte frame at 10 Mb/s, where each byte is repeated 100 times, under a 200 ppm clock mismatch (one entry of drift per 5000 symbols). Sticky flags record writes into a full buffer and reads from an empty one.

Top module: `eth_rx_elastic_buf`

## Requirements
- R1: After both resets, `overflow` and `underflow` are 0, `wr_level` and `rd_level` are 0, and `rd_idle` is 1.
- R2: The read side takes nothing from storage until `rd_level` has reached DEPTH/2. Until then it outputs idle (`rd_idle`=1) and never raises `underflow`. `rd_level` reports the exact count of stored symbols once the pointers are quiet.
- R3: While no overflow or underflow happens, every symbol written with `wr_idle`=0 appears exactly once on `rd_data` with `rd_idle`=0, in write order. A non-idle write into a buffer that is not full always advances the write position.
- R4: An incoming idle whose preceding written symbol was also idle is discarded when `wr_level` is at least DEPTH/2+HYST. A long idle gap with a write clock 10% faster than the read clock therefore holds `wr_level` at or below DEPTH/2+HYST without overflow.
- R5: The read side outputs an extra idle without advancing when the entry at its head is idle, the previous output was idle, and `rd_level` is at most DEPTH/2-HYST. A long gap with a write clock 10% slower than the read clock therefore keeps `rd_level` near DEPTH/2-HYST without underflow.
- R6: Once the gap has been corrected, the next frame is delivered intact after the drift.
- R7: A write that is neither discarded nor stored because `wr_level` equals DEPTH sets `overflow`. The flag stays 1 until `wr_rst_n` is asserted.
- R8: A read-side cycle after priming with `rd_level` 0 outputs idle and sets `underflow`. The flag stays 1 until `rd_rst_n` is asserted.
- R9: The read position and the write position each advance by at most one entry per cycle of their own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive byte clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Symbol present on the write side this cycle |
| wr_idle | input | 1 | 1 = incoming symbol is an idle/gap symbol |
| wr_data | input | 8 | Incoming byte |
| wr_level | output | 7 | Fill level as seen by the write domain |
| overflow | output | 1 | Sticky: write attempted into a full buffer |
| rd_clk | input | 1 | Local system clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_data | output | 8 | Outgoing byte, registered |
| rd_idle | output | 1 | 1 = outgoing symbol is idle |
| rd_level | output | 7 | Fill level as seen by the read domain |
| underflow | output | 1 | Sticky: read attempted from an empty buffer after priming |

## Verification
An output byte appears one read-clock edge after its entry reaches the head. A written entry becomes visible to the read side only after two read-clock edges of synchronization plus the write edge itself. A level therefore reaches its final value up to three cycles of the opposite clock after the other side has moved. The bench samples outputs on falling clock edges. It compares data by order through an expected-byte queue rather than by cycle. It reads levels and flags only after idle windows of tens of cycles, which are far longer than any of these latencies. The R2 count check stops the writes first, so the reported level is final when it is sampled.

// File: rtl/ebuf_pkg.sv
// Package: shared symbol type for the receive elastic buffer.
// Assumes byte-wide data with one flag bit that marks idle/gap symbols.
package ebuf_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              idle;
        logic [DATA_W-1:0] data;
    } sym_t;
endpackage

// File: rtl/ebuf_sync2.sv
// Two-flop synchronizer for a gray-coded pointer vector.
// Assumes at most one bit of d changes between consecutive source-clock edges.
module ebuf_sync2 #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ebuf_wr_ctl.sv
// Write-side control: owns the write pointer, discards surplus gap idles
// and records writes into a full buffer. Assumes the read pointer arrives
// gray-coded and already synchronized into wr_clk.
module ebuf_wr_ctl #(
    parameter int DEPTH = 64,
    parameter int HYST  = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          in_idle,
    input  logic [PW-1:0] rgray_sync,
    output logic [PW-1:0] wptr_bin,
    output logic [PW-1:0] wptr_gray,
    output logic          we,
    output logic          del,
    output logic [PW-1:0] level,
    output logic          overflow
);
    localparam logic [PW-1:0] DEL_AT = PW'(DEPTH / 2 + HYST);
    localparam logic [PW-1:0] FULL   = PW'(DEPTH);

    logic [PW-1:0] rbin;
    logic [PW-1:0] wnext;
    logic          prev_idle;
    logic          full;

    // Convert the synchronized read pointer from gray to binary.
    always_comb begin
        rbin[PW-1] = rgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rgray_sync[i];
        end
    end

    // Level, deletion eligibility and store decision.
    always_comb begin
        level = wptr_bin - rbin;
        full  = (level == FULL);
        del   = wr_en && in_idle && prev_idle && (level >= DEL_AT);
        we    = wr_en && !del && !full;
        wnext = wptr_bin + PW'(we);
    end

    // Pointer, gap tracking and sticky overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
            prev_idle <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            wptr_bin  <= wnext;
            wptr_gray <= wnext ^ (wnext >> 1);
            if (wr_en) begin
                prev_idle <= in_idle;
            end
            if (wr_en && !del && full) begin
                overflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ebuf_rd_ctl.sv
// Read-side control: waits for half occupancy, then drains one entry per
// cycle, repeats gap idles when the level is low and records empty reads.
// Assumes the write pointer arrives gray-coded and synchronized into rd_clk.
module ebuf_rd_ctl #(
    parameter int DEPTH = 64,
    parameter int HYST  = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        wgray_sync,
    input  ebuf_pkg::sym_t       head,
    output logic [PW-1:0]        rptr_bin,
    output logic [PW-1:0]        rptr_gray,
    output logic                 adv,
    output logic                 started,
    output logic [PW-1:0]        level,
    output ebuf_pkg::sym_t       out_sym,
    output logic                 underflow
);
    localparam logic [PW-1:0] MIDL   = PW'(DEPTH / 2);
    localparam logic [PW-1:0] INS_AT = PW'(DEPTH / 2 - HYST);

    logic [PW-1:0] wbin;
    logic [PW-1:0] rnext;
    logic          empty;
    logic          insert;

    // Convert the synchronized write pointer from gray to binary.
    always_comb begin
        wbin[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_sync[i];
        end
    end

    // Level, idle insertion and advance decision.
    always_comb begin
        level  = wbin - rptr_bin;
        empty  = (level == '0);
        insert = head.idle && out_sym.idle && (level <= INS_AT);
        adv    = started && !empty && !insert;
        rnext  = rptr_bin + PW'(adv);
    end

    // Pointer, priming, output symbol and sticky underflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_bin     <= '0;
            rptr_gray    <= '0;
            started      <= 1'b0;
            out_sym.idle <= 1'b1;
            out_sym.data <= '0;
            underflow    <= 1'b0;
        end else begin
            rptr_bin  <= rnext;
            rptr_gray <= rnext ^ (rnext >> 1);
            if (!started && level >= MIDL) begin
                started <= 1'b1;
            end
            if (adv) begin
                out_sym <= head;
            end else begin
                out_sym.idle <= 1'b1;
                out_sym.data <= '0;
            end
            if (started && empty) begin
                underflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/eth_rx_elastic_buf.sv
// Receive elastic buffer: dual-clock symbol store whose fill level is
// recentred only by deleting or repeating idles inside the interframe gap.
// Assumes DEPTH is a power of two and HYST is at least the pointer
// synchronization lag, so deletion and insertion never act together.
module eth_rx_elastic_buf #(
    parameter int DEPTH = 64,
    parameter int HYST  = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int DW = ebuf_pkg::DATA_W
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic          wr_idle,
    input  logic [DW-1:0] wr_data,
    output logic [PW-1:0] wr_level,
    output logic          overflow,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_idle,
    output logic [PW-1:0] rd_level,
    output logic          underflow
);
    ebuf_pkg::sym_t mem [DEPTH];
    ebuf_pkg::sym_t head;
    ebuf_pkg::sym_t out_sym;

    logic [PW-1:0] wptr_bin, wptr_gray, wgray_sync;
    logic [PW-1:0] rptr_bin, rptr_gray, rgray_sync;
    logic          wr_we, wr_del, rd_adv, rd_started;

    ebuf_sync2 #(.W(PW)) u_rsync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rgray_sync)
    );

    ebuf_sync2 #(.W(PW)) u_wsync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wgray_sync)
    );

    ebuf_wr_ctl #(.DEPTH(DEPTH), .HYST(HYST)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .in_idle(wr_idle),
        .rgray_sync(rgray_sync), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
        .we(wr_we), .del(wr_del), .level(wr_level), .overflow(overflow)
    );

    ebuf_rd_ctl #(.DEPTH(DEPTH), .HYST(HYST)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .wgray_sync(wgray_sync), .head(head),
        .rptr_bin(rptr_bin), .rptr_gray(rptr_gray), .adv(rd_adv),
        .started(rd_started), .level(rd_level), .out_sym(out_sym),
        .underflow(underflow)
    );

    // Store the incoming symbol at the write address.
    always_ff @(posedge wr_clk) begin
        if (wr_we) begin
            mem[wptr_bin[AW-1:0]] <= '{idle: wr_idle, data: wr_data};
        end
    end

    // Present the entry at the read address to the read controller.
    always_comb begin
        head    = mem[rptr_bin[AW-1:0]];
        rd_data = out_sym.data;
        rd_idle = out_sym.idle;
    end
endmodule

// File: rtl/ebuf_checker.sv
// Checker: temporal properties of the receive elastic buffer, bound to the
// top module. Assumes it sees the top's internal pointer and control nets.
module ebuf_checker #(
    parameter int DEPTH = 64,
    parameter int HYST  = 4,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_en,
    input logic          wr_idle,
    input logic [PW-1:0] wr_level,
    input logic [PW-1:0] wptr,
    input logic          del,
    input logic          overflow,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic [PW-1:0] rptr,
    input logic [PW-1:0] rd_level,
    input logic          rd_adv,
    input logic          rd_started,
    input logic          rd_idle,
    input logic          underflow
);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    assert_frame_byte_kept_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !wr_idle && wr_level != FULL) |=> (wptr == $past(wptr) + PW'(1)));

    assert_no_wr_skip_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ((wptr - $past(wptr)) <= PW'(1)));

    assert_no_rd_skip_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ((rptr - $past(rptr)) <= PW'(1)));

    assert_overflow_set_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !del && wr_level == FULL) |=> overflow);

    assert_overflow_sticky_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow);

    assert_underflow_sticky_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        underflow |=> underflow);

    assert_no_early_underflow_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_started |-> !underflow);

    assert_hold_gives_idle_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_started && rd_level != '0 && !rd_adv) |=> rd_idle);
endmodule

bind eth_rx_elastic_buf ebuf_checker #(.DEPTH(DEPTH), .HYST(HYST)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_idle(wr_idle),
    .wr_level(wr_level), .wptr(wptr_bin), .del(wr_del), .overflow(overflow),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rptr(rptr_bin), .rd_level(rd_level),
    .rd_adv(rd_adv), .rd_started(rd_started), .rd_idle(rd_idle),
    .underflow(underflow)
);

// File: tb/tb_eth_rx_elastic_buf.sv
`timescale 1ns/1ps
module tb_eth_rx_elastic_buf;
    localparam int DEPTH = 64;
    localparam int HYST  = 4;
    localparam int MID   = DEPTH / 2;
    localparam int PW    = $clog2(DEPTH) + 1;

    // Stimulus vector: frame length, first byte, gap length, write clock half period (x0.1 ns).
    typedef struct packed {
        logic [7:0]  len;
        logic [7:0]  seed;
        logic [7:0]  gap;
        logic [7:0]  half_x10;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{len: 8'd40, seed: 8'h10, gap: 8'd30, half_x10: 8'd100},
        '{len: 8'd60, seed: 8'h40, gap: 8'd40, half_x10: 8'd95},
        '{len: 8'd60, seed: 8'h80, gap: 8'd40, half_x10: 8'd105},
        '{len: 8'd1,  seed: 8'hC0, gap: 8'd24, half_x10: 8'd100},
        '{len: 8'd50, seed: 8'h05, gap: 8'd60, half_x10: 8'd95},
        '{len: 8'd50, seed: 8'h60, gap: 8'd60, half_x10: 8'd105},
        '{len: 8'd64, seed: 8'hA0, gap: 8'd30, half_x10: 8'd100},
        '{len: 8'd2,  seed: 8'hF0, gap: 8'd24, half_x10: 8'd105}
    };

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_idle = 1'b1;
    logic [7:0]    wr_data = '0;
    logic [PW-1:0] wr_level, rd_level;
    logic          overflow, underflow, rd_idle;
    logic [7:0]    rd_data;

    real           wr_half = 10.0;
    int            checks = 0, fails = 0;
    bit            mon_en = 1'b0;
    logic [7:0]    exp_q [$];

    always #10 rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    eth_rx_elastic_buf #(.DEPTH(DEPTH), .HYST(HYST)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_idle(wr_idle),
        .wr_data(wr_data), .wr_level(wr_level), .overflow(overflow),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data), .rd_idle(rd_idle),
        .rd_level(rd_level), .underflow(underflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic idle, input logic [7:0] data);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_idle = idle;
        wr_data = data;
    endtask

    task automatic send_gap(input int n);
        for (int i = 0; i < n; i++) send(1'b1, 8'h00);
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            if (mon_en) exp_q.push_back(seed + 8'(i));
            send(1'b0, seed + 8'(i));
        end
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (6) @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        @(negedge rd_clk);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3000 && exp_q.size() > 0; i++) @(negedge rd_clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // Output monitor: each non-idle output byte must be the next expected byte (R3).
    always @(negedge rd_clk) begin
        if (mon_en && rd_rst_n && !rd_idle) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected byte", int'(rd_data), -1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                check(rd_data == e, "R3 byte order", int'(rd_data), int'(e));
            end
        end
    end

    // Watchdog: an expired run counts as a miscompare and still prints the summary.
    initial begin
        repeat (150000) @(posedge rd_clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state.
        check(overflow == 1'b0 && underflow == 1'b0, "R1 flags", int'({overflow, underflow}), 0);
        check(wr_level == '0 && rd_level == '0, "R1 levels", int'(rd_level), 0);
        check(rd_idle == 1'b1, "R1 rd_idle", int'(rd_idle), 1);

        // R2: 20 idles, then stop writing; reader stays unprimed and reports exact count.
        send_gap(20);
        @(negedge wr_clk) wr_en = 1'b0;
        repeat (20) @(negedge rd_clk);
        check(int'(rd_level) == 20, "R2 level before priming", int'(rd_level), 20);
        check(underflow == 1'b0 && rd_idle == 1'b1, "R2 unprimed output", int'({underflow, rd_idle}), 1);

        // Prime with idles, then walk the vector table with drifting write clocks.
        send_gap(60);
        mon_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            wr_half = real'(VECS[v].half_x10) / 10.0;
            send_frame(int'(VECS[v].len), VECS[v].seed);
            send_gap(int'(VECS[v].gap));
        end
        drain("R3 table drained");
        check(overflow == 1'b0 && underflow == 1'b0, "R3 no flags on table", int'({overflow, underflow}), 0);

        // R4: long gap with a 10% faster write clock.
        wr_half = 9.0;
        send_gap(700);
        check(int'(wr_level) <= MID + HYST && int'(wr_level) >= MID - HYST, "R4 level capped",
              int'(wr_level), MID + HYST);
        check(overflow == 1'b0, "R4 no overflow", int'(overflow), 0);

        // R5: long gap with a 10% slower write clock.
        wr_half = 11.0;
        send_gap(700);
        check(int'(rd_level) >= MID - HYST - 2 && int'(rd_level) <= MID + 2, "R5 level held",
              int'(rd_level), MID - HYST);
        check(underflow == 1'b0, "R5 no underflow", int'(underflow), 0);

        // R6: frame after recentering arrives intact.
        send_frame(60, 8'h33);
        send_gap(40);
        drain("R6 frame after recentre");

        // R7: fast write of a long frame overflows; flag is sticky.
        mon_en = 1'b0;
        exp_q.delete();
        wr_half = 5.0;
        send_frame(200, 8'h00);
        send_gap(10);
        check(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
        send_gap(200);
        check(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);

        // R8: slow write of a long frame underflows; flag is sticky.
        wr_half = 20.0;
        send_gap(80);
        send_frame(150, 8'h00);
        check(underflow == 1'b1, "R8 underflow set", int'(underflow), 1);
        send_gap(100);
        check(underflow == 1'b1, "R8 underflow sticky", int'(underflow), 1);

        // R1: reset clears sticky flags.
        wr_half = 10.0;
        do_reset();
        check(overflow == 1'b0 && underflow == 1'b0, "R1 flags cleared", int'({overflow, underflow}), 0);
        check(rd_idle == 1'b1 && rd_level == '0, "R1 output after reset", int'(rd_level), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule